// File: doc/BRIEF.md
# Chainable FIFO Cell With Ownership Tokens

This block is a first-in first-out buffer, nine bits wide and 1024 words deep by default, that either works on its own or serves as one link in a ring of identical cells that together behave as a single deeper buffer. In a ring, two ownership tokens circulate. The holder of the write token takes the incoming words, and the holder of the read token supplies the outgoing words. A cell passes a token to its neighbour when it writes into, or reads from, its last storage location.

Each cell drives a registered expansion pulse with a type bit (write hand-off or read hand-off) into the expansion input of the next cell. The last cell feeds the first. Two static straps set the role of a cell. `chain_mode` low selects standalone operation, which corresponds to a grounded expansion input. `first_load_n` low marks the cell that starts out holding both tokens. The full and empty flags are active low and describe only this cell's own occupancy, so the ring's combined flags come from logic outside the block.

Top module: `dchain_fifo_cell`

## Requirements
- R1: With `chain_mode` low, writes and reads are gated only by the cell's own full and empty state. The expansion inputs have no effect, and `xout_pulse` stays low.
- R2: `full_n` is low exactly when DEPTH words are held, and `empty_n` is low exactly when none are held. A write while full or a read while empty is dropped and leaves the contents, the flags and `rd_data` unchanged.
- R3: Words leave in the order they were written. An accepted read places its word on `rd_data` at the clock edge that accepts it. `rd_data` holds its value in every cycle without an accepted read.
- R4: Reset clears the contents, so `empty_n`=0, `full_n`=1, `half_full`=0, `xout_pulse`=0 and `rd_data`=0. In chain mode, a cell with `first_load_n`=0 comes out of reset holding both tokens, and any other cell holds neither.
- R5: In chain mode, a write is accepted only while the cell holds the write token, and a read only while it holds the read token.
- R6: In chain mode, a write into location DEPTH-1 releases the write token. In the next cycle `xout_pulse`=1 for one cycle with `xout_is_rd`=0.
- R7: In chain mode, a read from location DEPTH-1 releases the read token. In the next cycle `xout_pulse`=1 for one cycle with `xout_is_rd`=1.
- R8: In chain mode, `xin_pulse`=1 at a clock edge grants the token named by `xin_is_rd` (0 = write token, 1 = read token) at that edge. The token is usable from the following cycle.
- R9: With `chain_mode` low, `half_full` is 1 when more than DEPTH/2 words are held and 0 otherwise. With `chain_mode` high, `half_full` is always 0.
- R10: With `chain_mode` low, `retx` moves the read position back to location 0 and sets the held count to the write position, and any write or read in that cycle is dropped. With `chain_mode` high, `retx` has no effect.
- R11: The write and read positions wrap from DEPTH-1 back to 0, and ordering is preserved across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_mode | input | 1 | Static strap: 1 = ring member, 0 = standalone |
| first_load_n | input | 1 | Static strap: 0 = cell that starts with both tokens |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read, registered |
| retx | input | 1 | Rewind the read position (standalone only) |
| xin_pulse | input | 1 | Token arrival from the previous cell |
| xin_is_rd | input | 1 | Type of arriving token: 1 = read, 0 = write |
| xout_pulse | output | 1 | Token hand-off to the next cell |
| xout_is_rd | output | 1 | Type of departing token: 1 = read, 0 = write |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_full | output | 1 | More than half of the locations in use |

## Verification
The checker assumes that `chain_mode` and `first_load_n` change only while reset is asserted. It also assumes that the rest of the ring never sends a token the cell already holds. The bench changes both straps only inside its reset task. It raises `xin_pulse` only after the cell has given the matching token away, or when the cell started without it. The properties about dropped requests leave out cycles with `retx` high, because a rewind legitimately changes the held count. The bench issues `retx` in isolated cycles, and the reference model tracks the rewind so that no comparison depends on that exclusion.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
   typedef enum logic {
      XFER_WR = 1'b0,
      XFER_RD = 1'b1
   } xfer_e;
endpackage

// File: rtl/dchain_store.sv
module dchain_store #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 1024,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= cells[raddr];
   end
endmodule

// File: rtl/dchain_ptr_ctrl.sv
module dchain_ptr_ctrl #(
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ok,
   input  logic          rd_ok,
   input  logic          rtx_ok,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [CW-1:0] count,
   output logic          wr_last,
   output logic          rd_last
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] wptr_nxt, rptr_nxt;

   assign wr_last = (wptr == LAST);
   assign rd_last = (rptr == LAST);

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2_wrap
         assign wptr_nxt = wptr + 1'b1;
         assign rptr_nxt = rptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wptr_nxt = wr_last ? '0 : wptr + 1'b1;
         assign rptr_nxt = rd_last ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (rtx_ok) begin
         rptr  <= '0;
         count <= CW'(wptr);
      end else begin
         if (wr_ok) wptr <= wptr_nxt;
         if (rd_ok) rptr <= rptr_nxt;
         count <= count + CW'(wr_ok) - CW'(rd_ok);
      end
   end
endmodule

// File: rtl/dchain_token_ctrl.sv
module dchain_token_ctrl
   import dchain_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic chain_mode,
   input  logic first_load_n,
   input  logic wr_req,
   input  logic rd_req,
   input  logic rtx_ok,
   input  logic is_full,
   input  logic is_empty,
   input  logic wr_last,
   input  logic rd_last,
   input  logic xin_pulse,
   input  logic xin_is_rd,
   output logic wr_ok,
   output logic rd_ok,
   output logic xout_pulse,
   output logic xout_is_rd
);
   logic  hold_wr, hold_rd;
   logic  hand_wr, hand_rd;
   logic  get_wr, get_rd;
   xfer_e in_kind;

   assign in_kind = xfer_e'(xin_is_rd);

   assign wr_ok = wr_req && !rtx_ok && !is_full  && (!chain_mode || hold_wr);
   assign rd_ok = rd_req && !rtx_ok && !is_empty && (!chain_mode || hold_rd);

   assign hand_wr = chain_mode && wr_ok && wr_last;
   assign hand_rd = chain_mode && rd_ok && rd_last;

   assign get_wr = chain_mode && xin_pulse && (in_kind == XFER_WR);
   assign get_rd = chain_mode && xin_pulse && (in_kind == XFER_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_wr    <= chain_mode && !first_load_n;
         hold_rd    <= chain_mode && !first_load_n;
         xout_pulse <= 1'b0;
         xout_is_rd <= 1'b0;
      end else begin
         hold_wr    <= (hold_wr && !hand_wr) || get_wr;
         hold_rd    <= (hold_rd && !hand_rd) || get_rd;
         xout_pulse <= hand_wr || hand_rd;
         xout_is_rd <= hand_rd;
      end
   end
endmodule

// File: rtl/dchain_fifo_cell.sv
module dchain_fifo_cell #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chain_mode,
   input  logic              first_load_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              retx,
   input  logic              xin_pulse,
   input  logic              xin_is_rd,
   output logic              xout_pulse,
   output logic              xout_is_rd,
   output logic              full_n,
   output logic              empty_n,
   output logic              half_full
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int HALF = DEPTH / 2;

   generate
      if (DEPTH < 4 || (DEPTH % 2) != 0) begin : g_bad_depth
         $error("dchain_fifo_cell: DEPTH must be even and at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dchain_fifo_cell: DATA_W must be positive");
      end
   endgenerate

   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          wr_last, rd_last;
   logic          wr_ok, rd_ok, rtx_ok;
   logic          is_full, is_empty;

   assign rtx_ok   = retx && !chain_mode;
   assign is_full  = (count == CW'(DEPTH));
   assign is_empty = (count == '0);

   assign full_n    = !is_full;
   assign empty_n   = !is_empty;
   assign half_full = !chain_mode && (count > CW'(HALF));

   dchain_token_ctrl tok_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .chain_mode   (chain_mode),
      .first_load_n (first_load_n),
      .wr_req       (wr_en),
      .rd_req       (rd_en),
      .rtx_ok       (rtx_ok),
      .is_full      (is_full),
      .is_empty     (is_empty),
      .wr_last      (wr_last),
      .rd_last      (rd_last),
      .xin_pulse    (xin_pulse),
      .xin_is_rd    (xin_is_rd),
      .wr_ok        (wr_ok),
      .rd_ok        (rd_ok),
      .xout_pulse   (xout_pulse),
      .xout_is_rd   (xout_is_rd)
   );

   dchain_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ok   (wr_ok),
      .rd_ok   (rd_ok),
      .rtx_ok  (rtx_ok),
      .wptr    (wptr),
      .rptr    (rptr),
      .count   (count),
      .wr_last (wr_last),
      .rd_last (rd_last)
   );

   dchain_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok),
      .waddr (wptr),
      .wdata (wr_data),
      .re    (rd_ok),
      .raddr (rptr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/dchain_fifo_chk.sv
module dchain_fifo_chk #(
   parameter int DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chain_mode,
   input logic              wr_en,
   input logic              rd_en,
   input logic              retx,
   input logic [DATA_W-1:0] rd_data,
   input logic              xout_pulse,
   input logic              full_n,
   input logic              empty_n,
   input logic              half_full
);
   // R1
   solo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_mode |-> !xout_pulse);

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && wr_en && !rd_en && !retx) |=> !full_n);

   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && rd_en && !wr_en && !retx) |=> (!empty_n && $stable(rd_data)));

   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R9
   hf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_mode && !full_n) |-> half_full);

   // R9
   hf_off_in_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chain_mode |-> !half_full);
endmodule

bind dchain_fifo_cell dchain_fifo_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dchain_fifo_cell_tb_top.sv
module dchain_fifo_cell_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TB_DEPTH   = 16;
   localparam int DW         = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chain_mode = 1'b0;
   logic          first_load_n = 1'b1;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          retx = 1'b0;
   logic          xin_pulse = 1'b0;
   logic          xin_is_rd = 1'b0;
   logic          xout_pulse, xout_is_rd, full_n, empty_n, half_full;

   int total = 0;
   int bad   = 0;
   bit armed = 0;
   bit done  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dchain_fifo_cell #(.DATA_W(DW), .DEPTH(TB_DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .first_load_n(first_load_n),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .retx(retx), .xin_pulse(xin_pulse), .xin_is_rd(xin_is_rd),
      .xout_pulse(xout_pulse), .xout_is_rd(xout_is_rd),
      .full_n(full_n), .empty_n(empty_n), .half_full(half_full)
   );

   // behavioural reference model
   int m_mem [TB_DEPTH];
   int m_cnt, m_wp, m_rp, m_rd;
   bit m_wtok, m_rtok, m_xo, m_xr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_wp = 0; m_rp = 0; m_rd = 0; m_xo = 0; m_xr = 0;
         m_wtok = chain_mode && !first_load_n;
         m_rtok = m_wtok;
      end else begin
         bit solo, rtx, wacc, racc, nxo, nxr;
         solo = !chain_mode;
         rtx  = retx && solo;
         wacc = wr_en && !rtx && (solo || m_wtok) && (m_cnt < TB_DEPTH);
         racc = rd_en && !rtx && (solo || m_rtok) && (m_cnt > 0);
         nxo = 0; nxr = 0;
         if (racc) begin
            m_rd = m_mem[m_rp];
            if (m_rp == TB_DEPTH - 1 && !solo) begin m_rtok = 0; nxo = 1; nxr = 1; end
            m_rp = (m_rp + 1) % TB_DEPTH;
         end
         if (wacc) begin
            m_mem[m_wp] = int'(wr_data);
            if (m_wp == TB_DEPTH - 1 && !solo) begin m_wtok = 0; nxo = 1; nxr = 0; end
            m_wp = (m_wp + 1) % TB_DEPTH;
         end
         m_cnt = m_cnt + int'(wacc) - int'(racc);
         if (rtx) begin m_rp = 0; m_cnt = m_wp; end
         if (!solo && xin_pulse) begin
            if (xin_is_rd) m_rtok = 1; else m_wtok = 1;
         end
         m_xo = nxo; m_xr = nxr;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (armed && !done) begin
         chk("R2 full_n",    int'(full_n),    int'(m_cnt != TB_DEPTH));
         chk("R2 empty_n",   int'(empty_n),   int'(m_cnt != 0));
         chk("R9 half_full", int'(half_full), int'(!chain_mode && m_cnt > TB_DEPTH / 2));
         chk("R3 rd_data",   int'(rd_data),   m_rd);
         chk("R6 R7 xout_pulse", int'(xout_pulse), int'(m_xo));
         chk("R6 R7 xout_is_rd", int'(xout_is_rd), int'(m_xr));
      end
   end

   task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r);
      wr_en = w; wr_data = d; rd_en = r;
      @(negedge clk);
      wr_en = 0; rd_en = 0; retx = 0; xin_pulse = 0; xin_is_rd = 0;
   endtask

   task automatic do_reset(input logic chain, input logic fl_n);
      rst_n = 0;
      chain_mode = chain;
      first_load_n = fl_n;
      repeat (2) @(negedge clk);
      rst_n = 1;
      armed = 1;
   endtask

   task automatic report();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   function automatic logic [DW-1:0] val(input int i);
      return DW'(i * 37 + 5);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      report();
   end

   initial begin
      @(negedge clk);
      // ---------- standalone mode ----------
      do_reset(0, 1);
      chk("R4 empty_n after reset", int'(empty_n), 0);
      chk("R4 full_n after reset", int'(full_n), 1);
      chk("R4 half_full after reset", int'(half_full), 0);
      chk("R4 xout after reset", int'(xout_pulse), 0);
      chk("R4 rd_data after reset", int'(rd_data), 0);

      for (int i = 0; i < 9; i++) cyc(1, val(i), 0);
      chk("R9 half_full above half", int'(half_full), 1);
      cyc(0, 0, 1);
      chk("R9 half_full at half", int'(half_full), 0);
      chk("R3 first word out", int'(rd_data), int'(val(0)));
      xin_pulse = 1; xin_is_rd = 0;
      cyc(1, val(9), 0);
      for (int i = 10; i < 17; i++) cyc(1, val(i), 0);
      chk("R2 full reached", int'(full_n), 0);
      chk("R1 no hand-off standalone", int'(xout_pulse), 0);
      cyc(1, 9'h1FF, 0);
      chk("R2 overflow write dropped", int'(full_n), 0);
      for (int i = 1; i < 17; i++) cyc(0, 0, 1);
      chk("R2 empty after drain", int'(empty_n), 0);
      chk("R3 last word out", int'(rd_data), int'(val(16)));
      cyc(0, 0, 1);
      chk("R2 underflow read keeps data", int'(rd_data), int'(val(16)));
      for (int i = 0; i < 3; i++) cyc(1, val(40 + i), 0);
      for (int i = 0; i < 3; i++) cyc(0, 0, 1);
      chk("R11 data across wrap", int'(rd_data), int'(val(42)));
      for (int i = 0; i < 48; i++) cyc(i % 3 != 0, val(60 + i), i % 2 == 0);

      // retransmit
      do_reset(0, 1);
      for (int i = 0; i < 5; i++) cyc(1, val(100 + i), 0);
      for (int i = 0; i < 3; i++) cyc(0, 0, 1);
      retx = 1;
      cyc(1, 9'h0AA, 1);
      chk("R10 count restored", int'(empty_n), 1);
      chk("R10 read in rewind cycle dropped", int'(rd_data), int'(val(102)));
      cyc(0, 0, 1);
      chk("R10 rewound to location 0", int'(rd_data), int'(val(100)));
      for (int i = 0; i < 4; i++) cyc(0, 0, 1);
      chk("R10 count equals write position", int'(empty_n), 0);

      // ---------- chain mode, first cell ----------
      do_reset(1, 0);
      for (int i = 0; i < 16; i++) cyc(1, val(200 + i), 0);
      chk("R6 write hand-off pulse", int'(xout_pulse), 1);
      chk("R6 write hand-off type", int'(xout_is_rd), 0);
      chk("R9 half_full off in chain", int'(half_full), 0);
      cyc(0, 0, 0);
      chk("R6 pulse lasts one cycle", int'(xout_pulse), 0);
      cyc(0, 0, 1);
      cyc(1, 9'h055, 0);
      chk("R5 write without token dropped", int'(full_n), 1);
      retx = 1;
      cyc(0, 0, 1);
      chk("R10 retx ignored in chain", int'(rd_data), int'(val(201)));
      for (int i = 2; i < 16; i++) cyc(0, 0, 1);
      chk("R7 read hand-off pulse", int'(xout_pulse), 1);
      chk("R7 read hand-off type", int'(xout_is_rd), 1);
      chk("R7 drained", int'(empty_n), 0);

      // ---------- chain mode, other cell ----------
      do_reset(1, 1);
      cyc(1, 9'h1A1, 0);
      chk("R5 no write token at start", int'(empty_n), 0);
      xin_pulse = 1; xin_is_rd = 0;
      cyc(0, 0, 0);
      cyc(1, 9'h1A1, 0);
      chk("R8 write token granted", int'(empty_n), 1);
      cyc(0, 0, 1);
      chk("R5 no read token", int'(rd_data), 0);
      chk("R5 word kept", int'(empty_n), 1);
      xin_pulse = 1; xin_is_rd = 1;
      cyc(0, 0, 0);
      cyc(0, 0, 1);
      chk("R8 read token granted", int'(rd_data), 9'h1A1);
      cyc(0, 0, 0);
      report();
   end
endmodule